// File: doc/BRIEF.md
# Flash Write-Status Read Responder

This block sits between a flash array and its read port and decides what a read returns while an internal program or erase is in progress. An accepted operation start makes the block busy for a programmable number of clock cycles. While it is busy, every read returns a status word instead of array data. Bit 7 of that word reports completion according to the operation type. Bit 6 flips on every read. All other bits read as zero.

When the busy time ends, the operation is committed to a small register model of the array. A program clears bits, so the word becomes old AND new. An erase sets every word to all ones. The first read after completion returns only the true bit 7 of the addressed word. From the next read on, full array words are returned.

A host polls the read port after starting an operation. It stops polling when bit 7 matches the expected value or when bit 6 stops changing. Operation starts that arrive while busy are dropped.

Top module: `flash_wstatus_resp`

## Requirements
- R1: After reset, `busy` and `rdValid` are 0 and `rdData` is 0x0000. Every array word holds 0xFFFF.
- R2: A read strobe sampled at a clock edge makes `rdValid` high for exactly the following cycle, with `rdData` updated at that same edge. Without a strobe, `rdValid` is low.
- R3: While idle, a read returns the array word at `rdAddr`.
- R4: While a program (`opErase`=0) is busy, a read returns bit 7 as the inverse of bit 7 of the word being programmed. Bits 15..8 and 5..0 are 0.
- R5: While an erase (`opErase`=1) is busy, a read returns bit 7 as 0. Bits 15..8 and 5..0 are 0.
- R6: Bit 6 of a busy read is 1 on the first read after an accepted start, and it inverts on each further busy read. The toggle restarts on each new operation.
- R7: `busy` rises one cycle after an accepted start and stays high for `durCycles` cycles. A value of 0 is treated as 1.
- R8: An `opStart` while busy is ignored. The running operation keeps its type, word and address, and only it is committed.
- R9: At completion, a program sets the word at its address to old AND programmed word. Other words are unchanged.
- R10: At completion, an erase sets every array word to 0xFFFF.
- R11: The first read after completion returns bit 7 of the addressed array word with all other bits 0. Later reads return the full word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opStart | input | 1 | Start an internal operation (accepted when not busy) |
| opErase | input | 1 | Operation type: 0 program, 1 erase |
| opAddr | input | ADDR_W | Word address for a program |
| opWord | input | DATA_W | Word to program |
| durCycles | input | CNT_W | Busy duration in clock cycles |
| rdStb | input | 1 | Read strobe |
| rdAddr | input | ADDR_W | Read address |
| busy | output | 1 | Internal operation running |
| rdValid | output | 1 | Read response valid |
| rdData | output | DATA_W | Read response word |

## Verification
The bench polls across several busy windows and targets the toggle restart. The first operation ends with the toggle at an odd count, so a design that keeps the toggle from one operation to the next returns bit 6 as 0 on the next first read. An erase start is issued in the middle of a program. A design that accepts it would change the status bit 7 or leave the word at all ones. The read directly after completion is checked for a bare bit 7, which catches a design that returns the full word too early or keeps reporting status. Busy length is measured for an ordinary duration and for zero, which catches off-by-one counting and a stuck busy.

// File: rtl/fwsr_pkg.sv
`timescale 1ns/1ps
package fwsr_pkg;
  typedef enum logic {OP_PROG = 1'b0, OP_ERASE = 1'b1} opKind_t;
  typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_SETTLE} ctrlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchOp;   // capture operation, restart toggle
    logic commitOp;  // apply operation to array model
    logic opActive;  // operation in progress
    logic rdArray;   // plain array read
    logic rdStatus;  // status read while busy
    logic rdSettle;  // first read after completion
  } ctrlStb_t;
endpackage

// File: rtl/fwsr_ctrl.sv
`timescale 1ns/1ps
module fwsr_ctrl
  import fwsr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opStart,
  input  logic [CNT_W-1:0] durCycles,
  input  logic             rdStb,
  output ctrlStb_t         stb,
  output logic             busy
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  ctrlState_t state, stateNxt;
  logic [CNT_W-1:0] remCnt, remNxt;
  logic startOk;
  logic lastCycle;

  assign startOk   = opStart && (state != ST_BUSY);
  assign lastCycle = (state == ST_BUSY) && (remCnt == ONE);

  always_comb begin
    stateNxt = state;
    remNxt   = remCnt;
    unique case (state)
      ST_IDLE: begin
        if (startOk) begin
          stateNxt = ST_BUSY;
          remNxt   = (durCycles == '0) ? ONE : durCycles;
        end
      end
      ST_BUSY: begin
        if (lastCycle) stateNxt = ST_SETTLE;
        else           remNxt   = remCnt - ONE;
      end
      ST_SETTLE: begin
        if (startOk) begin
          stateNxt = ST_BUSY;
          remNxt   = (durCycles == '0) ? ONE : durCycles;
        end else if (rdStb) begin
          stateNxt = ST_IDLE;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      remCnt <= '0;
    end else begin
      state  <= stateNxt;
      remCnt <= remNxt;
    end
  end

  always_comb begin
    stb.latchOp  = startOk;
    stb.commitOp = lastCycle;
    stb.opActive = (state == ST_BUSY);
    stb.rdArray  = rdStb && (state == ST_IDLE);
    stb.rdStatus = rdStb && (state == ST_BUSY);
    stb.rdSettle = rdStb && (state == ST_SETTLE);
  end

  assign busy = (state == ST_BUSY);

  // R7: busy drops right after the last counted cycle
  p_busy_end_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && remCnt == ONE) |=> !busy);
  // R7: busy keeps going while cycles remain
  p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && remCnt != ONE) |=> busy);
  // R8: a start while busy is not taken
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && opStart) |-> !stb.latchOp);
  // R2/R11: read classes are exclusive
  p_rd_onehot_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.rdArray, stb.rdStatus, stb.rdSettle}));
endmodule

// File: rtl/fwsr_datapath.sv
`timescale 1ns/1ps
module fwsr_datapath
  import fwsr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStb_t          stb,
  input  logic              opErase,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic [DATA_W-1:0] opWord,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData
);
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int POLL_B  = 7;
  localparam int TOG_B   = 6;

  opKind_t           kindQ;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wordQ;
  logic              toggleQ;
  logic [DATA_W-1:0] mem [DEPTH];

  logic [DATA_W-1:0] arrayWord;
  logic [DATA_W-1:0] statusWord;
  logic [DATA_W-1:0] settleWord;
  logic              pollBit;

  // operation capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      kindQ <= OP_PROG;
      addrQ <= '0;
      wordQ <= '0;
    end else if (stb.latchOp) begin
      kindQ <= opErase ? OP_ERASE : OP_PROG;
      addrQ <= opAddr;
      wordQ <= opWord;
    end
  end

  // toggle bit: restarts per operation, advances per busy read
  always_ff @(posedge clk) begin
    if (!rstN)             toggleQ <= 1'b0;
    else if (stb.latchOp)  toggleQ <= 1'b0;
    else if (stb.rdStatus) toggleQ <= ~toggleQ;
  end

  // array register model
  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rstN) begin
        mem[gi] <= '1;
      end else if (stb.commitOp) begin
        if (kindQ == OP_ERASE)
          mem[gi] <= '1;
        else if (addrQ == ADDR_W'(gi))
          mem[gi] <= mem[gi] & wordQ;
      end
    end
  end

  assign arrayWord = mem[rdAddr];
  assign pollBit   = (kindQ == OP_PROG) ? ~wordQ[POLL_B] : 1'b0;

  always_comb begin
    statusWord         = '0;
    statusWord[POLL_B] = pollBit;
    statusWord[TOG_B]  = ~toggleQ;
    settleWord         = '0;
    settleWord[POLL_B] = arrayWord[POLL_B];
  end

  // read response register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= stb.rdArray | stb.rdStatus | stb.rdSettle;
      if (stb.rdStatus)      rdData <= statusWord;
      else if (stb.rdSettle) rdData <= settleWord;
      else if (stb.rdArray)  rdData <= arrayWord;
    end
  end

  // R2: a response follows each strobe and only a strobe
  p_rd_latency_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdArray | stb.rdStatus | stb.rdSettle) |=> rdValid);
  p_no_stray_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.rdArray | stb.rdStatus | stb.rdSettle) |=> !rdValid);
  // R4/R5: status word carries nothing outside bits 7 and 6
  p_status_pad_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.rdStatus |=> (rdData[DATA_W-1:8] == '0 && rdData[5:0] == '0));
  // R5: erase polling bit is low while busy
  p_erase_poll_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdStatus && kindQ == OP_ERASE) |=> !rdData[POLL_B]);
  // R8: captured operation stays put while active
  p_kind_stable_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.opActive && !stb.commitOp) |=> ($stable(kindQ) && $stable(wordQ) && $stable(addrQ)));
  // R11: settle read shows only bit 7
  p_settle_pad_r11: assert property (@(posedge clk) disable iff (!rstN)
    stb.rdSettle |=> (rdData[DATA_W-1:8] == '0 && rdData[6:0] == '0));
endmodule

// File: rtl/flash_wstatus_resp.sv
`timescale 1ns/1ps
module flash_wstatus_resp
  import fwsr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opStart,
  input  logic              opErase,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic [DATA_W-1:0] opWord,
  input  logic [CNT_W-1:0]  durCycles,
  input  logic              rdStb,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic              busy,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData
);
  ctrlStb_t stb;

  fwsr_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .opStart(opStart), .durCycles(durCycles),
    .rdStb(rdStb), .stb(stb), .busy(busy)
  );

  fwsr_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .opErase(opErase), .opAddr(opAddr),
    .opWord(opWord), .rdAddr(rdAddr), .rdValid(rdValid), .rdData(rdData)
  );
endmodule

// File: tb/flash_wstatus_resp_bench.sv
`timescale 1ns/1ps
module flash_wstatus_resp_bench;
  logic clk = 0;
  logic rstN = 0;
  logic opStart = 0, opErase = 0, rdStb = 0;
  logic [3:0] opAddr = '0, rdAddr = '0;
  logic [15:0] opWord = '0, durCycles = 16'd20;
  logic busy, rdValid;
  logic [15:0] rdData;

  int total = 0, bad = 0, cyc = 0;
  logic [15:0] expQ[$];
  string tagQ[$];

  always #2 clk = ~clk;

  flash_wstatus_resp u_flash_wstatus_resp (
    .clk(clk), .rstN(rstN), .opStart(opStart), .opErase(opErase),
    .opAddr(opAddr), .opWord(opWord), .durCycles(durCycles),
    .rdStb(rdStb), .rdAddr(rdAddr), .busy(busy), .rdValid(rdValid),
    .rdData(rdData)
  );

  task automatic checkEq(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: issue a read and queue its expected response
  task automatic doRead(logic [3:0] a, logic [15:0] exp, string tag);
    @(negedge clk);
    rdStb = 1; rdAddr = a;
    expQ.push_back(exp); tagQ.push_back(tag);
    @(negedge clk);
    rdStb = 0;
  endtask

  task automatic startOp(logic erase, logic [3:0] a, logic [15:0] w, logic [15:0] d);
    @(negedge clk);
    opStart = 1; opErase = erase; opAddr = a; opWord = w; durCycles = d;
    @(negedge clk);
    opStart = 0;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  // monitor: compare responses in order
  always @(negedge clk) begin
    if (rstN) begin
      if (rdValid) begin
        if (expQ.size() == 0) checkEq("R2 unexpected response", rdData, 16'hxxxx);
        else checkEq(tagQ.pop_front(), rdData, expQ.pop_front());
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    checkEq("R1 busy", {15'd0, busy}, 16'd0);
    checkEq("R1 rdValid", {15'd0, rdValid}, 16'd0);
    checkEq("R1 rdData", rdData, 16'h0000);
    doRead(4'd7, 16'hFFFF, "R1 R3 erased at reset");

    // program 0x12B4 at addr 3; measure busy (R7)
    @(negedge clk);
    opStart = 1; opErase = 0; opAddr = 4'd3; opWord = 16'h12B4; durCycles = 16'd20;
    @(negedge clk);
    opStart = 0;
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    checkEq("R7 busy length 20", 16'(n), 16'd20);
    doRead(4'd3, 16'h0080, "R11 settle bit7 after program");
    doRead(4'd3, 16'h12B4, "R9 R3 programmed word");
    doRead(4'd4, 16'hFFFF, "R9 other word untouched");

    // program with status polling, 3 reads (toggle ends odd)
    startOp(0, 4'd3, 16'h0F0F, 16'd30);
    doRead(4'd3, 16'h00C0, "R4 R6 first status read");
    doRead(4'd9, 16'h0080, "R4 R6 second status read");
    // R8: erase start during program is dropped
    startOp(1, 4'd0, 16'h0000, 16'd5);
    doRead(4'd3, 16'h00C0, "R8 R4 status after ignored start");
    waitIdle();
    doRead(4'd3, 16'h0000, "R11 settle bit7 low");
    doRead(4'd3, 16'h0204, "R8 R9 AND result, no erase");
    doRead(4'd3, 16'h0204, "R11 full word again");

    // erase; toggle restarts (R6)
    startOp(1, 4'd0, 16'h0000, 16'd25);
    doRead(4'd1, 16'h0040, "R5 R6 erase first status");
    doRead(4'd1, 16'h0000, "R5 R6 erase second status");
    doRead(4'd1, 16'h0040, "R5 R6 erase third status");
    waitIdle();
    doRead(4'd3, 16'h0080, "R11 R10 settle after erase");
    doRead(4'd3, 16'hFFFF, "R10 erased word");

    // zero duration counts as one cycle (R7)
    @(negedge clk);
    opStart = 1; opErase = 0; opAddr = 4'd5; opWord = 16'h00FF; durCycles = 16'd0;
    @(negedge clk);
    opStart = 0;
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    checkEq("R7 busy length for zero", 16'(n), 16'd1);
    doRead(4'd5, 16'h0080, "R11 settle after short program");
    doRead(4'd5, 16'h00FF, "R9 short program word");

    repeat (4) @(negedge clk);
    checkEq("R2 all responses seen", 16'(expQ.size()), 16'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule